// File: doc/BRIEF.md
# Time-Multiplexed Single-Port FIFO

This block is a synchronous first-in first-out buffer whose whole storage is a single-port memory. The memory is clocked at twice the user rate, and a phase bit splits each user (base) cycle into two fast cycles. The memory takes a write in the first slot and a read in the second. The user side can therefore push one word and pop one word in every base cycle without a second memory port and without a second bank. The sustained throughput is one word in each direction per base cycle, which is half the memory clock rate.

The user drives the write enable, write data and read enable at the start of a base cycle and holds them for both slots. The phase bit is visible on an output so that the surrounding logic can align to it. By default the block makes its own phase bit from the fast clock. A parameter can select an externally supplied phase bit instead. A popped word appears on the read data register when the base cycle closes and stays there until a later pop replaces it. The occupancy, the pointers and the full and empty flags change only at that same boundary.

Top module: `tmfifo_shared`

## Requirements
- R1: While reset is held, empty is 1, full is 0, rd_data is all zeros and rd_slot is 0.
- R2: With the internal phase source, rd_slot toggles on every rising edge of the fast clock after reset. rd_slot=0 marks the write slot and rd_slot=1 marks the read slot. The two slots together form one base cycle, which closes on the rising edge that ends the read slot.
- R3: The single memory port writes only during the write slot and reads only during the read slot, and never does both on the same fast edge.
- R4: A write is accepted when wr_en is 1 at the end of the write slot and the buffer is not full. Accepted words come out in the order they were written.
- R5: A read is accepted when rd_en is 1 at the end of the read slot and the buffer is not empty. The oldest word is then loaded into rd_data at the close of that base cycle and stays stable for the whole following base cycle.
- R6: A read and a write in the same base cycle both take effect and leave the occupancy unchanged. When the buffer is empty at the start of the cycle, the read is dropped and only the write takes effect.
- R7: A write while full is dropped, and the stored contents are unchanged. When the buffer is full and both a read and a write are requested in one base cycle, only the read takes effect.
- R8: A read while empty is dropped, and rd_data keeps its previous value.
- R9: full, empty and rd_data change only at the close of a base cycle, never at the end of a write slot.
- R10: The storage addresses wrap after DEPTH words, so FIFO order holds across any number of passes through the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the user rate |
| rst | input | 1 | Synchronous active-high reset |
| phase_in | input | 1 | External phase bit, used only when USE_EXT_PHASE=1 |
| rd_slot | output | 1 | Current slot: 0 write slot, 1 read slot |
| wr_en | input | 1 | Push request, held for the base cycle |
| wr_data | input | WIDTH | Word to push |
| rd_en | input | 1 | Pop request, held for the base cycle |
| rd_data | output | WIDTH | Registered popped word |
| full | output | 1 | DEPTH words stored |
| empty | output | 1 | No words stored |

## Verification
The bench goes after the occupancy edges. It pushes and pops together on an empty buffer, where a design that forwarded the new word would return it in the same base cycle. It does the same on a full buffer, where a design that judged the write after the read would store one word too many and overwrite the oldest word. It also applies a push to a full buffer and a pop to an empty one. A design that did not drop these would corrupt later data, or change rd_data without any word having been popped. Runs of several passes through the memory catch an address that wraps at the wrong count. Checking the flags and rd_data halfway through every base cycle catches an update made at the end of the write slot instead of at the boundary.

// File: rtl/tmfifo_pkg.sv
package tmfifo_pkg;

  // next storage address, wrapping after depth entries
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // occupancy after one base cycle with given accepted push/pop
  function automatic int unsigned occ_next(input int unsigned occ, input logic push, input logic pop);
    int unsigned n;
    n = occ;
    if (push && !pop) n = occ + 1;
    if (pop && !push) n = occ - 1;
    return n;
  endfunction

endpackage

// File: rtl/tmfifo_phase.sv
module tmfifo_phase #(
  parameter bit USE_EXT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic phase_in,
  output logic phase
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= 1'b0;
    else     phase_q <= ~phase_q;
  end

  assign phase = USE_EXT ? phase_in : phase_q;

  generate
    if (!USE_EXT) begin : g_int_chk
      AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (phase != $past(phase)));  // R2
    end
  endgenerate
endmodule

// File: rtl/tmfifo_spram.sv
module tmfifo_spram #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             we,
  input  logic             re,
  input  logic [WIDTH-1:0] wd,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= cells[addr];
  end

  AST_ONE_PORT_OP: assert property (@(posedge clk) disable iff (rst)
    !(we && re));  // R3
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (we || re) |-> (int'(addr) < DEPTH));  // R10
endmodule

// File: rtl/tmfifo_ctrl.sv
module tmfifo_ctrl
  import tmfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          phase,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic          full,
  output logic          empty
);
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] occ;
  logic          push_q;
  logic          boundary;

  assign full     = (int'(occ) == DEPTH);
  assign empty    = (occ == '0);
  assign mem_we   = !phase && wr_en && !full;
  assign mem_re   = phase && rd_en && !empty;
  assign mem_addr = phase ? rptr : wptr;
  assign boundary = phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      occ    <= '0;
      push_q <= 1'b0;
    end else if (!boundary) begin
      push_q <= mem_we;
    end else begin
      if (push_q) wptr <= AW'(wrap_inc(int'(wptr), DEPTH));
      if (mem_re) rptr <= AW'(wrap_inc(int'(rptr), DEPTH));
      occ    <= CW'(occ_next(int'(occ), push_q, mem_re));
      push_q <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= DEPTH);  // R7
  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    full |-> !mem_we);  // R7
  AST_EMPTY_NO_READ: assert property (@(posedge clk) disable iff (rst)
    empty |-> !mem_re);  // R8
  AST_WR_IN_SLOT0: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !phase);  // R3
  AST_OCC_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !phase |=> $stable(occ));  // R9
endmodule

// File: rtl/tmfifo_shared.sv
module tmfifo_shared #(
  parameter int WIDTH         = 8,
  parameter int DEPTH         = 16,
  parameter bit USE_EXT_PHASE = 1'b0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_in,
  output logic             rd_slot,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty
);
  logic          phase;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_addr;

  tmfifo_phase #(.USE_EXT(USE_EXT_PHASE)) u_phase (
    .clk(clk), .rst(rst), .phase_in(phase_in), .phase(phase)
  );

  tmfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .phase(phase), .wr_en(wr_en), .rd_en(rd_en),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .full(full), .empty(empty)
  );

  tmfifo_spram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst(rst), .addr(mem_addr), .we(mem_we), .re(mem_re),
    .wd(wr_data), .q(rd_data)
  );

  assign rd_slot = phase;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !phase |=> $stable(rd_data));  // R5
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));  // R9
endmodule

// File: tb/tb_tmfifo_shared.sv
module tb_tmfifo_shared;
  localparam int W = 8;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic full, empty, rd_slot;

  int vectors = 0;
  int miscmp = 0;
  bit done = 0;

  logic [W-1:0] model_q[$];
  logic [W-1:0] exp_rd = '0;

  always #4 clk = ~clk;

  tmfifo_shared #(.WIDTH(W), .DEPTH(D)) dut (
    .clk(clk), .rst(rst), .phase_in(1'b0), .rd_slot(rd_slot),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .full(full), .empty(empty)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one base cycle; called at a negedge inside a write slot
  task automatic base_cycle(input logic we, input logic [W-1:0] wd, input logic re);
    logic f0, e0;
    logic [W-1:0] r0;
    bit wacc, racc;
    wr_en = we; wr_data = wd; rd_en = re;
    check("R2 write slot", rd_slot, 1'b0);
    f0 = full; e0 = empty; r0 = rd_data;
    @(posedge clk); @(negedge clk);
    check("R2 read slot", rd_slot, 1'b1);
    check("R9 full mid", full, f0);
    check("R9 empty mid", empty, e0);
    check("R9 rd_data mid", rd_data, r0);
    @(posedge clk); @(negedge clk);
    wacc = we && (model_q.size() < D);
    racc = re && (model_q.size() > 0);
    if (racc) exp_rd = model_q.pop_front();
    if (wacc) model_q.push_back(wd);
    check("R4/R5/R6/R10 rd_data", rd_data, exp_rd);
    check("R7 full", full, model_q.size() == D);
    check("R8 empty", empty, model_q.size() == 0);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 empty", empty, 1'b1);
    check("R1 full", full, 1'b0);
    check("R1 rd_data", rd_data, '0);
    check("R1 rd_slot", rd_slot, 1'b0);
    rst = 1'b0;

    // R4/R5 basic push then pop
    for (int i = 0; i < 5; i++) base_cycle(1'b1, W'(8'h10 + i), 1'b0);
    for (int i = 0; i < 5; i++) base_cycle(1'b0, '0, 1'b1);
    // R8 pops on empty keep rd_data
    for (int i = 0; i < 3; i++) base_cycle(1'b0, '0, 1'b1);
    // R6 push and pop together on empty
    base_cycle(1'b1, 8'hA5, 1'b1);
    for (int i = 0; i < 6; i++) base_cycle(1'b1, W'(8'h30 + i), 1'b1);
    // R7 fill to full and push more
    for (int i = 0; i < D + 3; i++) base_cycle(1'b1, W'(8'h50 + i), 1'b0);
    // R7 full with both requests: only the pop takes effect
    base_cycle(1'b1, 8'hEE, 1'b1);
    base_cycle(1'b1, 8'hEF, 1'b0);
    // drain past empty
    for (int i = 0; i < D + 2; i++) base_cycle(1'b0, '0, 1'b1);
    // R10 several wraps, mixed traffic; R3 relies on data integrity here
    for (int i = 0; i < 600; i++)
      base_cycle(1'($urandom_range(0, 99) < 55), W'($urandom), 1'($urandom_range(0, 99) < 50));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule